// File: doc/BRIEF.md
# Privileged Virtual Address Segment Decoder

This block sorts every 32-bit virtual address into one of five fixed windows and decides, from the privilege mode and the error-level flag, what happens to the access. The address may go to an external TLB, be translated by a fixed subtraction, or be rejected. When the access fails, either because the current mode may not use the window or because the TLB reports a problem, the block picks the exception code. It also builds the values that the fault-capture registers must take: the faulting address, the page-table context word and the entry-high word.

The TLB sits outside the block and is combinational. In the request cycle the decoder raises `tlb_query` for mapped windows, and the TLB returns its result code, its physical address and its write permission in that same cycle. All results are registered and appear one cycle after the request. The fault-capture outputs load only when a fault is reported and keep their values otherwise.

The privilege mode is encoded as 00 kernel, 01 supervisor, 10 user, and 11, which is also treated as kernel. The TLB result is encoded as 0 hit, 1 no match, 2 invalid and 3 write to a clean page. Exception codes are 0 none, 1 TLB modify, 2 TLB load, 3 TLB store, 4 address-error load and 5 address-error store.

Top module: `vaddr_segment_decoder`

## Requirements
- R1: An address in 0x00000000..0x7FFFFFFF with `err_level` low raises `tlb_query` in the request cycle, in every mode, and takes its result from the TLB.
- R2: An address in 0x00000000..0x7FFFFFFF with `err_level` high is identity-mapped, with read and write permission and no TLB query.
- R3: An address in 0x80000000..0x9FFFFFFF in kernel mode (mode 00 or 11) maps to the physical address `vaddr - 0x80000000`, with read and write permission.
- R4: An address in 0xA0000000..0xBFFFFFFF in kernel mode maps to the physical address `vaddr - 0xA0000000`, with read and write permission.
- R5: An address in 0xC0000000..0xDFFFFFFF goes to the TLB in supervisor (01) or kernel mode and is rejected in user mode (10).
- R6: An address in 0xE0000000..0xFFFFFFFF goes to the TLB only in kernel mode and is rejected in supervisor and user mode.
- R7: A rejected access faults with code 5 on a write or code 4 on a read, with `refill` low. This covers both fixed windows outside kernel mode.
- R8: A TLB no-match faults with code 3 on a write or code 2 on a read, with `refill` high. A TLB invalid result gives the same codes with `refill` low.
- R9: A TLB clean-page result faults with code 1 in both directions, with `refill` low.
- R10: A TLB hit returns `tlb_pa` as the physical address, with read permission set and write permission equal to `tlb_writable`.
- R11: On a fault, `bad_vaddr` equals the virtual address. `context_val` takes `ctx_keep` in bits 31:23, vaddr[31:13] in bits 22:4 and zero in bits 3:0. `entryhi_val` takes vaddr[31:13] in bits 31:13, zero in bits 12:8 and `cur_asid` in bits 7:0.
- R12: Results appear one cycle after `req_valid`, with `resp_valid` high. A cycle without a request gives zero for `resp_valid`, `fault`, `exc_code`, `refill`, the physical address and the permissions. The capture outputs change only on a fault, and all outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| vaddr | input | 32 | Virtual address |
| is_write | input | 1 | 1 for a store, 0 for a load |
| priv_mode | input | 2 | 00 kernel, 01 supervisor, 10 user, 11 kernel |
| err_level | input | 1 | Error-level flag |
| cur_asid | input | 8 | Current address-space identifier |
| ctx_keep | input | 9 | Bits 31:23 of the current context word |
| tlb_query | output | 1 | Combinational: the address is sent to the TLB |
| tlb_result | input | 2 | TLB result for the queried address |
| tlb_pa | input | 32 | Physical address returned by the TLB |
| tlb_writable | input | 1 | The TLB page may be written |
| resp_valid | output | 1 | A result is presented |
| phys_addr | output | 32 | Translated physical address, zero on a fault |
| perm_rd | output | 1 | Read permission |
| perm_wr | output | 1 | Write permission |
| fault | output | 1 | The access raised an exception |
| exc_code | output | 5 | Exception code |
| refill | output | 1 | The fault needs a TLB refill |
| bad_vaddr | output | 32 | Captured faulting address |
| context_val | output | 32 | New context word |
| entryhi_val | output | 32 | New entry-high word |

## Verification
A wrong window decode shows in the response of the same access, one cycle after the request, as the wrong physical offset, a missing or spurious `tlb_query`, or a fault code where a translation was expected. A mistake in folding the TLB result shows at once as the wrong code or `refill` level. A capture register that loads when it should not, or misses a load, stays wrong until the next fault, so an idle cycle or a fault-free request placed after every fault exposes it on the next result cycle.

// File: rtl/seg_dec_pkg.sv
package seg_dec_pkg;

    typedef enum logic [1:0] {
        MODE_KERNEL = 2'b00,
        MODE_SUPER  = 2'b01,
        MODE_USER   = 2'b10,
        MODE_KALT   = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        TLBR_HIT     = 2'd0,
        TLBR_NOMATCH = 2'd1,
        TLBR_INVALID = 2'd2,
        TLBR_CLEAN   = 2'd3
    } tlbres_e;

    typedef enum logic [2:0] {
        WIN_USER,
        WIN_KDIRECT_A,
        WIN_KDIRECT_B,
        WIN_SUPER,
        WIN_KMAPPED
    } window_e;

    typedef enum logic [1:0] {
        ROUTE_TLB,
        ROUTE_FIXED,
        ROUTE_REJECT
    } route_e;

    localparam int EXC_W = 5;

    localparam logic [EXC_W-1:0] EXC_NONE       = 5'd0;
    localparam logic [EXC_W-1:0] EXC_TLB_MOD    = 5'd1;
    localparam logic [EXC_W-1:0] EXC_TLB_LOAD   = 5'd2;
    localparam logic [EXC_W-1:0] EXC_TLB_STORE  = 5'd3;
    localparam logic [EXC_W-1:0] EXC_ADDR_LOAD  = 5'd4;
    localparam logic [EXC_W-1:0] EXC_ADDR_STORE = 5'd5;

endpackage

// File: rtl/seg_window.sv
module seg_window
    import seg_dec_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic [1:0]      mode,
    input  logic            err_level,
    output window_e         window,
    output route_e          route,
    output logic [VA_W-1:0] fixed_pa
);
    localparam int TOP_W    = 3;
    localparam int LOW_W    = VA_W - TOP_W;

    logic is_kernel;
    logic is_super_up;

    always_comb begin
        is_kernel   = (mode != MODE_USER) && (mode != MODE_SUPER);
        is_super_up = is_kernel || (mode == MODE_SUPER);
    end

    always_comb begin
        window   = WIN_USER;
        route    = ROUTE_REJECT;
        fixed_pa = '0;
        unique case (vaddr[VA_W-1 -: TOP_W])
            3'b000, 3'b001, 3'b010, 3'b011: begin
                window = WIN_USER;
                if (err_level) begin
                    route    = ROUTE_FIXED;
                    fixed_pa = vaddr;
                end else begin
                    route = ROUTE_TLB;
                end
            end
            3'b100: begin
                window   = WIN_KDIRECT_A;
                route    = is_kernel ? ROUTE_FIXED : ROUTE_REJECT;
                fixed_pa = is_kernel ? {{TOP_W{1'b0}}, vaddr[LOW_W-1:0]} : '0;
            end
            3'b101: begin
                window   = WIN_KDIRECT_B;
                route    = is_kernel ? ROUTE_FIXED : ROUTE_REJECT;
                fixed_pa = is_kernel ? {{TOP_W{1'b0}}, vaddr[LOW_W-1:0]} : '0;
            end
            3'b110: begin
                window = WIN_SUPER;
                route  = is_super_up ? ROUTE_TLB : ROUTE_REJECT;
            end
            default: begin
                window = WIN_KMAPPED;
                route  = is_kernel ? ROUTE_TLB : ROUTE_REJECT;
            end
        endcase
    end

endmodule

// File: rtl/fault_map.sv
module fault_map
    import seg_dec_pkg::*;
(
    input  route_e           route,
    input  logic [1:0]       tlb_result,
    input  logic             is_write,
    output logic             fault,
    output logic [EXC_W-1:0] exc_code,
    output logic             refill
);
    tlbres_e res;

    always_comb begin
        res      = tlbres_e'(tlb_result);
        fault    = 1'b0;
        exc_code = EXC_NONE;
        refill   = 1'b0;
        unique case (route)
            ROUTE_REJECT: begin
                fault    = 1'b1;
                exc_code = is_write ? EXC_ADDR_STORE : EXC_ADDR_LOAD;
            end
            ROUTE_TLB: begin
                unique case (res)
                    TLBR_HIT: fault = 1'b0;
                    TLBR_NOMATCH: begin
                        fault    = 1'b1;
                        exc_code = is_write ? EXC_TLB_STORE : EXC_TLB_LOAD;
                        refill   = 1'b1;
                    end
                    TLBR_INVALID: begin
                        fault    = 1'b1;
                        exc_code = is_write ? EXC_TLB_STORE : EXC_TLB_LOAD;
                    end
                    default: begin
                        fault    = 1'b1;
                        exc_code = EXC_TLB_MOD;
                    end
                endcase
            end
            default: fault = 1'b0;
        endcase
    end

endmodule

// File: rtl/vaddr_segment_decoder.sv
module vaddr_segment_decoder
    import seg_dec_pkg::*;
#(
    parameter int ASID_W      = 8,
    parameter int PAIR_LSB    = 13,
    parameter int CTX_FLD_LSB = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [31:0]           vaddr,
    input  logic                  is_write,
    input  logic [1:0]            priv_mode,
    input  logic                  err_level,
    input  logic [ASID_W-1:0]     cur_asid,
    input  logic [31-(32-PAIR_LSB+CTX_FLD_LSB):0] ctx_keep,
    output logic                  tlb_query,
    input  logic [1:0]            tlb_result,
    input  logic [31:0]           tlb_pa,
    input  logic                  tlb_writable,
    output logic                  resp_valid,
    output logic [31:0]           phys_addr,
    output logic                  perm_rd,
    output logic                  perm_wr,
    output logic                  fault,
    output logic [EXC_W-1:0]      exc_code,
    output logic                  refill,
    output logic [31:0]           bad_vaddr,
    output logic [31:0]           context_val,
    output logic [31:0]           entryhi_val
);
    localparam int VA_W     = 32;
    localparam int PAIR_W   = VA_W - PAIR_LSB;
    localparam int CTX_TOP  = PAIR_W + CTX_FLD_LSB;
    localparam int KEEP_W   = VA_W - CTX_TOP;
    localparam int EH_PAD_W = PAIR_LSB - ASID_W;

    window_e          window;
    route_e           route;
    logic [VA_W-1:0]  fixed_pa;
    logic             nx_fault;
    logic [EXC_W-1:0] nx_code;
    logic             nx_refill;

    logic [VA_W-1:0]  nx_pa;
    logic             nx_rd;
    logic             nx_wr;
    logic [VA_W-1:0]  nx_ctx;
    logic [VA_W-1:0]  nx_eh;

    seg_window #(.VA_W(VA_W)) u_window (
        .vaddr     (vaddr),
        .mode      (priv_mode),
        .err_level (err_level),
        .window    (window),
        .route     (route),
        .fixed_pa  (fixed_pa)
    );

    fault_map u_fault (
        .route      (route),
        .tlb_result (tlb_result),
        .is_write   (is_write),
        .fault      (nx_fault),
        .exc_code   (nx_code),
        .refill     (nx_refill)
    );

    assign tlb_query = req_valid && (route == ROUTE_TLB);

    always_comb begin
        nx_pa = '0;
        nx_rd = 1'b0;
        nx_wr = 1'b0;
        if (!nx_fault) begin
            unique case (route)
                ROUTE_FIXED: begin
                    nx_pa = fixed_pa;
                    nx_rd = 1'b1;
                    nx_wr = 1'b1;
                end
                ROUTE_TLB: begin
                    nx_pa = tlb_pa;
                    nx_rd = 1'b1;
                    nx_wr = tlb_writable;
                end
                default: nx_pa = '0;
            endcase
        end
        nx_ctx = {ctx_keep[KEEP_W-1:0], vaddr[VA_W-1:PAIR_LSB], {CTX_FLD_LSB{1'b0}}};
        nx_eh  = {vaddr[VA_W-1:PAIR_LSB], {EH_PAD_W{1'b0}}, cur_asid};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            phys_addr   <= '0;
            perm_rd     <= 1'b0;
            perm_wr     <= 1'b0;
            fault       <= 1'b0;
            exc_code    <= EXC_NONE;
            refill      <= 1'b0;
            bad_vaddr   <= '0;
            context_val <= '0;
            entryhi_val <= '0;
        end else begin
            resp_valid <= req_valid;
            phys_addr  <= req_valid ? nx_pa : '0;
            perm_rd    <= req_valid && nx_rd;
            perm_wr    <= req_valid && nx_wr;
            fault      <= req_valid && nx_fault;
            exc_code   <= req_valid ? nx_code : EXC_NONE;
            refill     <= req_valid && nx_refill;
            if (req_valid && nx_fault) begin
                bad_vaddr   <= vaddr;
                context_val <= nx_ctx;
                entryhi_val <= nx_eh;
            end
        end
    end

    logic unused_window;
    assign unused_window = ^window;

endmodule

// File: rtl/vaddr_segment_decoder_chk.sv
module vaddr_segment_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] vaddr,
    input logic        is_write,
    input logic [1:0]  priv_mode,
    input logic        err_level,
    input logic        tlb_query,
    input logic        resp_valid,
    input logic [31:0] phys_addr,
    input logic        perm_rd,
    input logic        perm_wr,
    input logic        fault,
    input logic [4:0]  exc_code,
    input logic        refill,
    input logic [31:0] bad_vaddr,
    input logic [31:0] context_val,
    input logic [31:0] entryhi_val
);
    logic kmode;
    assign kmode = (priv_mode == 2'b00) || (priv_mode == 2'b11);

    assert_query_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_query |-> (!vaddr[31] && !err_level) || (vaddr[31:30] == 2'b11));

    assert_identity_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !vaddr[31] && err_level) |=>
            (!fault && phys_addr == $past(vaddr) && perm_rd && perm_wr));

    assert_kdirect_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && vaddr[31:29] == 3'b100 && kmode) |=>
            (!fault && phys_addr == $past(vaddr) - 32'h8000_0000));

    assert_kdirect_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && vaddr[31:29] == 3'b101 && kmode) |=>
            (!fault && phys_addr == $past(vaddr) - 32'hA000_0000));

    assert_user_reject_super_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && vaddr[31:29] == 3'b110 && priv_mode == 2'b10) |=>
            (fault && !refill));

    assert_kmapped_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && vaddr[31:29] == 3'b111 && !kmode) |=>
            (fault && exc_code == ($past(is_write) ? 5'd5 : 5'd4)));

    assert_refill_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        refill |-> (fault && (exc_code == 5'd2 || exc_code == 5'd3)));

    assert_capture_align_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (entryhi_val[31:13] == bad_vaddr[31:13] &&
                   context_val[22:4] == bad_vaddr[31:13]));

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!resp_valid && !fault && $stable(bad_vaddr) &&
                        $stable(context_val) && $stable(entryhi_val)));

    assert_fault_no_perm_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!perm_rd && !perm_wr && resp_valid));

endmodule

bind vaddr_segment_decoder vaddr_segment_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .vaddr       (vaddr),
    .is_write    (is_write),
    .priv_mode   (priv_mode),
    .err_level   (err_level),
    .tlb_query   (tlb_query),
    .resp_valid  (resp_valid),
    .phys_addr   (phys_addr),
    .perm_rd     (perm_rd),
    .perm_wr     (perm_wr),
    .fault       (fault),
    .exc_code    (exc_code),
    .refill      (refill),
    .bad_vaddr   (bad_vaddr),
    .context_val (context_val),
    .entryhi_val (entryhi_val)
);

// File: tb/vaddr_segment_decoder_test.sv
module vaddr_segment_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] vaddr = '0;
    logic        is_write = 1'b0;
    logic [1:0]  priv_mode = 2'b00;
    logic        err_level = 1'b0;
    logic [7:0]  cur_asid = '0;
    logic [8:0]  ctx_keep = '0;
    logic        tlb_query;
    logic [1:0]  tlb_result = '0;
    logic [31:0] tlb_pa = '0;
    logic        tlb_writable = 1'b0;
    logic        resp_valid;
    logic [31:0] phys_addr;
    logic        perm_rd;
    logic        perm_wr;
    logic        fault;
    logic [4:0]  exc_code;
    logic        refill;
    logic [31:0] bad_vaddr;
    logic [31:0] context_val;
    logic [31:0] entryhi_val;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    vaddr_segment_decoder uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vaddr(vaddr),
        .is_write(is_write), .priv_mode(priv_mode), .err_level(err_level),
        .cur_asid(cur_asid), .ctx_keep(ctx_keep), .tlb_query(tlb_query),
        .tlb_result(tlb_result), .tlb_pa(tlb_pa), .tlb_writable(tlb_writable),
        .resp_valid(resp_valid), .phys_addr(phys_addr), .perm_rd(perm_rd),
        .perm_wr(perm_wr), .fault(fault), .exc_code(exc_code), .refill(refill),
        .bad_vaddr(bad_vaddr), .context_val(context_val), .entryhi_val(entryhi_val)
    );

    // expected response of one access
    logic        e_query, e_fault, e_refill, e_rd, e_wr, e_valid;
    logic [4:0]  e_code;
    logic [31:0] e_pa;
    logic [31:0] e_bad = '0, e_ctx = '0, e_eh = '0;
    string       e_tag;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model(input logic [31:0] va, input logic wr, input logic [1:0] md,
                         input logic erl, input logic [1:0] tr, input logic [31:0] tpa,
                         input logic twr);
        logic kern, sup, mapped, bad;
        kern = (md != 2'b01) && (md != 2'b10);
        sup  = kern || (md == 2'b01);
        mapped = 0; bad = 0;
        e_pa = '0; e_rd = 0; e_wr = 0; e_fault = 0; e_code = 0; e_refill = 0;
        if (va < 32'h8000_0000) begin
            if (erl) begin e_pa = va; e_rd = 1; e_wr = 1; e_tag = "R2"; end
            else begin mapped = 1; e_tag = "R1"; end
        end else if (va < 32'hA000_0000) begin
            if (kern) begin e_pa = va - 32'h8000_0000; e_rd = 1; e_wr = 1; e_tag = "R3"; end
            else begin bad = 1; e_tag = "R7"; end
        end else if (va < 32'hC000_0000) begin
            if (kern) begin e_pa = va - 32'hA000_0000; e_rd = 1; e_wr = 1; e_tag = "R4"; end
            else begin bad = 1; e_tag = "R7"; end
        end else if (va < 32'hE000_0000) begin
            e_tag = "R5";
            if (sup) mapped = 1; else bad = 1;
        end else begin
            e_tag = "R6";
            if (kern) mapped = 1; else bad = 1;
        end
        e_query = mapped;
        if (bad) begin
            e_fault = 1; e_code = wr ? 5'd5 : 5'd4;
        end else if (mapped) begin
            case (tr)
                2'd0: begin e_pa = tpa; e_rd = 1; e_wr = twr; e_tag = "R10"; end
                2'd1: begin e_fault = 1; e_code = wr ? 5'd3 : 5'd2; e_refill = 1; e_tag = "R8"; end
                2'd2: begin e_fault = 1; e_code = wr ? 5'd3 : 5'd2; e_tag = "R8"; end
                default: begin e_fault = 1; e_code = 5'd1; e_tag = "R9"; end
            endcase
        end
    endtask

    task automatic check_result();
        chk("R12", {31'd0, resp_valid}, {31'd0, e_valid}, "resp_valid");
        chk(e_tag, {31'd0, fault}, {31'd0, e_fault}, "fault");
        chk(e_tag, {27'd0, exc_code}, {27'd0, e_code}, "exc_code");
        chk(e_tag, {31'd0, refill}, {31'd0, e_refill}, "refill");
        chk(e_tag, phys_addr, e_pa, "phys_addr");
        chk(e_tag, {30'd0, perm_rd, perm_wr}, {30'd0, e_rd, e_wr}, "perm");
        // R11 on a fault, R12 hold otherwise
        chk(e_fault ? "R11" : "R12", bad_vaddr, e_bad, "bad_vaddr");
        chk(e_fault ? "R11" : "R12", context_val, e_ctx, "context_val");
        chk(e_fault ? "R11" : "R12", entryhi_val, e_eh, "entryhi_val");
    endtask

    task automatic access(input logic v, input logic [31:0] va, input logic wr,
                          input logic [1:0] md, input logic erl, input logic [1:0] tr);
        logic [31:0] tpa;
        logic        twr;
        tpa = $urandom;
        twr = 1'($urandom);
        @(negedge clk);
        req_valid = v; vaddr = va; is_write = wr; priv_mode = md; err_level = erl;
        tlb_result = tr; tlb_pa = tpa; tlb_writable = twr;
        cur_asid = 8'($urandom); ctx_keep = 9'($urandom);
        model(va, wr, md, erl, tr, tpa, twr);
        #1;
        chk("R1", {31'd0, tlb_query}, {31'd0, v && e_query}, "tlb_query");
        e_valid = v;
        if (!v) begin
            e_fault = 0; e_code = 0; e_refill = 0; e_pa = '0; e_rd = 0; e_wr = 0;
            e_tag = "R12";
        end
        if (v && e_fault) begin
            e_bad = va;
            e_ctx = {ctx_keep, va[31:13], 4'd0};
            e_eh  = {va[31:13], 5'd0, cur_asid};
        end
        @(negedge clk);
        req_valid = 0;
        check_result();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0001));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state, R12
        e_valid = 0; e_fault = 0; e_code = 0; e_refill = 0; e_pa = 0;
        e_rd = 0; e_wr = 0; e_tag = "R12";
        check_result();
        rst_n = 1'b1;

        // window boundaries across modes
        access(1, 32'h7FFF_FFFF, 0, 2'b10, 0, 2'd0);  // R1 user TLB hit
        access(1, 32'h0000_0000, 1, 2'b10, 1, 2'd1);  // R2 identity despite miss code
        access(1, 32'h8000_0000, 0, 2'b00, 0, 2'd1);  // R3
        access(1, 32'h9FFF_FFFF, 1, 2'b11, 0, 2'd0);  // R3 alt kernel
        access(1, 32'hA000_0000, 1, 2'b00, 0, 2'd3);  // R4
        access(1, 32'hBFFF_FFFF, 0, 2'b00, 0, 2'd0);  // R4
        access(1, 32'h8123_4567, 1, 2'b01, 0, 2'd0);  // R7 store
        access(1, 32'hB000_1000, 0, 2'b10, 0, 2'd0);  // R7 load
        access(0, 32'hFFFF_FFFF, 1, 2'b10, 0, 2'd0);  // R12 idle holds capture
        access(1, 32'hC000_0000, 0, 2'b01, 0, 2'd0);  // R5 super hit
        access(1, 32'hDFFF_FFFF, 1, 2'b10, 0, 2'd0);  // R5 user rejected
        access(1, 32'hE000_0000, 0, 2'b01, 0, 2'd0);  // R6 super rejected
        access(1, 32'hFFFF_FFFF, 1, 2'b00, 0, 2'd0);  // R6 kernel hit
        access(1, 32'h1234_5000, 1, 2'b10, 0, 2'd1);  // R8 store refill
        access(1, 32'h1234_5000, 0, 2'b10, 0, 2'd2);  // R8 load invalid
        access(1, 32'hC555_A000, 0, 2'b00, 0, 2'd3);  // R9 read
        access(1, 32'h4000_2000, 1, 2'b01, 0, 2'd3);  // R9 write
        access(1, 32'h0000_0000, 0, 2'b10, 0, 2'd0);  // R12 no-fault keeps capture

        for (int i = 0; i < 3000; i++) begin
            access(($urandom % 8) != 0, $urandom, 1'($urandom), 2'($urandom),
                   ($urandom % 4) == 0, 2'($urandom));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule